// File: doc/BRIEF.md
# Five-Function Integer ALU

This block is the arithmetic and logic stage of a small single-cycle processor datapath. It is purely combinational. Two 32-bit operands and a 3-bit function code go in. A 32-bit result and a flag that marks an all-zero result come out. The datapath feeds register values into the operands and routes the result to writeback or address generation. The zero flag drives branch decisions.

One adder serves both addition and subtraction. The top bit of the function code inverts operand b and also supplies the carry-in, so subtraction is computed as a + ~b + 1. The less-than function takes the sign bit of that difference as it is, with no overflow correction. It therefore gives a wrong answer for some operand pairs of mixed sign. There is no overflow output, and all arithmetic wraps modulo 2^32.

Top module: `alu32_core`

## Requirements
- R1: Function code 3'b000 gives result = op_a & op_b, bit by bit.
- R2: Function code 3'b001 gives result = op_a | op_b, bit by bit.
- R3: Function code 3'b010 gives result = (op_a + op_b) mod 2^32. The carry out is discarded, so 0xFFFFFFFF + 1 gives 0.
- R4: Function code 3'b110 gives result = (op_a + ~op_b + 1) mod 2^32, which is op_a − op_b with wraparound. For example, 0 − 1 gives 0xFFFFFFFF.
- R5: Function code 3'b111 places bit 31 of (op_a − op_b) in result bit 0 and clears result bits 31..1. No overflow correction is applied, so a = 0xD8A3B8D3 with b = 0x63B9D6F2 gives 0.
- R6: zero is 1 exactly when all 32 result bits are 0, for every function code.
- R7: Function codes 3'b011, 3'b100 and 3'b101 give a result of 0, and therefore zero = 1.
- R8: There is no clock and no state. Both outputs follow the current inputs within one combinational settle, and a new input pattern replaces the previous answer completely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; inverted for subtract and less-than |
| op_sel | input | 3 | Function code; bit 2 is the invert-b and carry-in control |
| result | output | 32 | Function result |
| zero | output | 1 | 1 when result is all zeros |

## Verification
The block holds no state, so any internal fault appears at the ports within the same evaluation as the inputs that expose it. If the invert-b or carry-in path is wrong, the subtract result is off by one or fully wrong. The less-than bit then disagrees with bit 31 of a true difference computed in the bench. A selection fault shows up in one of two ways. An unused code produces a nonzero result, or a result of zero appears with the zero flag low. The signed-overflow operand pair is included on purpose, so that a design which corrects for overflow is reported.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
    typedef enum logic [2:0] {
        FN_AND = 3'b000,
        FN_OR  = 3'b001,
        FN_ADD = 3'b010,
        FN_SUB = 3'b110,
        FN_SLT = 3'b111
    } alu_fn_e;
endpackage

// File: rtl/alu32_bitwise.sv
// Per-bit AND and OR lanes.
module alu32_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] and_out,
    output logic [WIDTH-1:0] or_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign and_out[i] = in_a[i] & in_b[i];
        assign or_out[i]  = in_a[i] | in_b[i];
    end
endmodule

// File: rtl/alu32_addsub.sv
// Shared adder: negate_b inverts b and also supplies the carry-in.
module alu32_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             negate_b,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] cin_ext;

    always_comb begin
        b_eff   = negate_b ? ~in_b : in_b;
        cin_ext = {{(WIDTH-1){1'b0}}, negate_b};
        sum     = in_a + b_eff + cin_ext;
    end
endmodule

// File: rtl/alu32_select.sv
// Result selection; unused codes give zero.
module alu32_select #(
    parameter int WIDTH = 32
) (
    input  logic [2:0]       fn,
    input  logic [WIDTH-1:0] and_in,
    input  logic [WIDTH-1:0] or_in,
    input  logic [WIDTH-1:0] sum_in,
    output logic [WIDTH-1:0] sel_out
);
    import alu32_pkg::*;

    logic [WIDTH-1:0] lt_word;

    always_comb begin
        lt_word = {{(WIDTH-1){1'b0}}, sum_in[WIDTH-1]};
        case (fn)
            FN_AND:  sel_out = and_in;
            FN_OR:   sel_out = or_in;
            FN_ADD,
            FN_SUB:  sel_out = sum_in;
            FN_SLT:  sel_out = lt_word;
            default: sel_out = '0;
        endcase
    end
endmodule

// File: rtl/alu32_core.sv
module alu32_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             zf;
    } alu_out_t;

    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] or_w;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] sel_w;
    alu_out_t         out_d;

    alu32_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .in_a    (op_a),
        .in_b    (op_b),
        .and_out (and_w),
        .or_out  (or_w)
    );

    alu32_addsub #(.WIDTH(WIDTH)) u_addsub (
        .in_a     (op_a),
        .in_b     (op_b),
        .negate_b (op_sel[2]),
        .sum      (sum_w)
    );

    alu32_select #(.WIDTH(WIDTH)) u_select (
        .fn      (op_sel),
        .and_in  (and_w),
        .or_in   (or_w),
        .sum_in  (sum_w),
        .sel_out (sel_w)
    );

    always_comb begin
        out_d.res = sel_w;
        out_d.zf  = (sel_w == '0);
    end

    assign result = out_d.res;
    assign zero   = out_d.zf;
endmodule

// File: rtl/alu32_core_chk.sv
module alu32_core_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero
);
    always_comb begin
        if (op_sel == 3'b000) AST_AND_SUBSET: assert ((result & ~op_a) == '0); // R1
        if (op_sel == 3'b001) AST_OR_SUPERSET: assert ((result & op_a) == op_a); // R2
        if (op_sel == 3'b010) AST_ADD_INVERSE: assert (result - op_b == op_a); // R3
        if (op_sel == 3'b110) AST_SUB_INVERSE: assert (result + op_b == op_a); // R4
        if (op_sel == 3'b111) AST_SLT_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0); // R5
        AST_ZERO_FLAG: assert (zero == (result == '0)); // R6
        if (op_sel == 3'b011 || op_sel == 3'b100 || op_sel == 3'b101)
            AST_UNUSED_ZERO: assert (zero && result == '0); // R7
    end
endmodule

bind alu32_core alu32_core_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a   (op_a),
    .op_b   (op_b),
    .op_sel (op_sel),
    .result (result),
    .zero   (zero)
);

// File: tb/alu32_core_test.sv
module alu32_core_test;
    logic        clk = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  op_sel = '0;
    logic [31:0] result;
    logic        zero;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    alu32_core #(.WIDTH(32)) uut (
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .result(result), .zero(zero)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] s);
        logic [31:0] d;
        d = a - b;
        case (s)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b110:  return d;
            3'b111:  return {31'd0, d[31]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic expect_out(input string req, input logic [31:0] exp_r, input logic exp_z);
        n_checks++;
        if (result !== exp_r || zero !== exp_z) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h sel=%b got result=%h zero=%b expected result=%h zero=%b",
                     req, op_a, op_b, op_sel, result, zero, exp_r, exp_z);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] s);
        @(negedge clk);
        op_a = a; op_b = b; op_sel = s;
        #1;
    endtask

    task automatic run_vec(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic [2:0] s, input logic [31:0] exp_r);
        apply(a, b, s);
        expect_out(req, exp_r, exp_r == 32'd0);
        // cross-check against bench model
        expect_out({req, "_model"}, model(a, b, s), model(a, b, s) == 32'd0);
    endtask

    task automatic test_idle_state;  // R6 all-zero inputs
        apply(32'd0, 32'd0, 3'b000);
        expect_out("R6", 32'd0, 1'b1);
    endtask

    task automatic test_and;  // R1
        run_vec("R1", 32'h0F0F0F0F, 32'hF0F0F0F0, 3'b000, 32'h0);
        run_vec("R1", 32'hFFFFFFFF, 32'hFFFF0000, 3'b000, 32'hFFFF0000);
        run_vec("R1", 32'hD8A3B8D3, 32'h63B9D6F2, 3'b000, 32'h40A190D2);
    endtask

    task automatic test_or;  // R2
        run_vec("R2", 32'h0F0F0F0F, 32'hF0F0F0F0, 3'b001, 32'hFFFFFFFF);
        run_vec("R2", 32'h0, 32'h0, 3'b001, 32'h0);
        run_vec("R2", 32'hD8A3B8D3, 32'h63B9D6F2, 3'b001, 32'hFBBBFEF3);
    endtask

    task automatic test_add;  // R3
        run_vec("R3", 32'h4FFFFFFF, 32'h00000001, 3'b010, 32'h50000000);
        run_vec("R3", 32'hFFFFFFFF, 32'h00000001, 3'b010, 32'h0);
        run_vec("R3", 32'hD8A3B8D3, 32'h63B9D6F2, 3'b010, 32'h3C5D8FC5);
    endtask

    task automatic test_sub;  // R4
        run_vec("R4", 32'h0, 32'h1, 3'b110, 32'hFFFFFFFF);
        run_vec("R4", 32'h1, 32'h30000001, 3'b110, 32'hD0000000);
        run_vec("R4", 32'h1, 32'h1, 3'b110, 32'h0);
        run_vec("R4", 32'hD8A3B8D3, 32'h63B9D6F2, 3'b110, 32'h74E9E1E1);
    endtask

    task automatic test_slt;  // R5
        run_vec("R5", 32'h0, 32'h1, 3'b111, 32'h1);
        run_vec("R5", 32'h1, 32'h30000001, 3'b111, 32'h1);
        run_vec("R5", 32'h1, 32'h1, 3'b111, 32'h0);
        run_vec("R5", 32'h5, 32'h3, 3'b111, 32'h0);
        run_vec("R5", 32'hD8A3B8D3, 32'h63B9D6F2, 3'b111, 32'h0);  // sign of wrapped diff
    endtask

    task automatic test_unused;  // R7
        run_vec("R7", 32'hFFFFFFFF, 32'h12345678, 3'b011, 32'h0);
        run_vec("R7", 32'hFFFFFFFF, 32'h12345678, 3'b100, 32'h0);
        run_vec("R7", 32'hA5A5A5A5, 32'h00000001, 3'b101, 32'h0);
    endtask

    task automatic test_follow;  // R8 answer replaced at once on new inputs
        apply(32'hFFFFFFFF, 32'h00000001, 3'b010);
        expect_out("R8", 32'h0, 1'b1);
        op_a = 32'h00000010; #1;
        expect_out("R8", 32'h00000011, 1'b0);
        op_sel = 3'b001; #1;
        expect_out("R8", 32'h00000011, 1'b0);
    endtask

    task automatic test_random;  // R5 bit 31 of a-b, all codes vs model
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b, d;
            logic [2:0]  s;
            a = $urandom; b = $urandom; s = 3'($urandom);
            d = a - b;
            apply(a, b, 3'b111);
            expect_out("R5_rand", {31'd0, d[31]}, ~d[31]);
            apply(a, b, s);
            expect_out("R6_rand", model(a, b, s), model(a, b, s) == 32'd0);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, got cycles=%0d expected completion", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234));
        test_idle_state();
        test_and();
        test_or();
        test_add();
        test_sub();
        test_slt();
        test_unused();
        test_follow();
        test_random();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule